// File: doc/BRIEF.md
# Power-Management Activity Detector and Wake Controller

This block watches the activity sources of a small system: interrupt lines 1 to 15, six DMA request lines, an AC adapter input, a software-settable flag and a memory-mapped cycle strobe. It turns their rising edges into a single-cycle activity pulse. It also holds the current power mode and decides when that mode changes. An eight-bit activity mask chooses which sources count. Activity that is not masked lifts the system from Doze or Low-Speed PLL mode up to High-Speed PLL mode. A separate three-bit resume mask chooses which of IRQ3, IRQ4 and IRQ8 may bring the system out of Sleep, Suspend or Off.

Detection is suppressed while an SMI or NMI is being serviced. An event that falls in that window is lost for good; it is not held back for later. An external step-down controller can load a new mode through a mode-set strobe. Both masks are read and written over a one-address-bit register port.

Top module: `pmu_wake_ctrl`

## Requirements
- R1: After reset the activity mask and resume mask read 0, the mode output is 5 (High-Speed PLL) and the activity pulse is low.
- R2: A write with address 0 loads the 8-bit activity mask. A write with address 1 loads the resume mask into bits 2:0. Read data follows the address combinationally, and bits 7:3 of the resume mask read as 0.
- R3: A rising edge on any unmasked source gives exactly one high cycle on the activity pulse, on the third rising clock edge after the input changes. Holding the input high gives no further pulse, and a falling edge gives none.
- R4: Activity mask bit positions: 7 covers IRQ2 through IRQ15, 6 covers AC input, 5 the memory-mapped strobe, 4 IRQ1, 3 DRQ3, 2 DRQ2, 1 DRQ1, and 0 covers DRQ5, DRQ6 and DRQ7 together. A bit value of 1 suppresses its source, and a value of 0 lets it count.
- R5: AC activity is a rising edge of the adapter input or of the software flag. It counts only when mask bit 6 is 0 and the AC enable input is 1.
- R6: While the SMI or NMI busy input is high at the clock edge that would register an event, the event is dropped. It gives no pulse and no mode change, neither then nor later.
- R7: Mode encoding is 0 Off, 1 Suspend, 2 Sleep, 3 Doze, 4 Low-Speed PLL, 5 High-Speed PLL. In mode 3 or 4, counted activity sets the mode to 5 on the same edge that raises the pulse.
- R8: In modes 0, 1 or 2, counted activity on its own leaves the mode unchanged.
- R9: Resume mask bit 0 enables IRQ3, bit 1 enables IRQ4 and bit 2 enables IRQ8. From modes 0 to 2, a rising edge on an enabled one sets the mode to 5, whatever the activity mask says.
- R10: A mode-set strobe loads a value from 0 to 5 on the next edge. Values 6 and 7 are ignored. When the same edge also raises or wakes the mode, the raise or wake wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 15 | Interrupt lines IRQ1..IRQ15 (bit n is IRQn) |
| drq_lo_i | input | 3 | DMA requests DRQ1..DRQ3 (bit n is DRQn) |
| drq_hi_i | input | 3 | DMA requests DRQ5..DRQ7 (bit n is DRQn) |
| ac_in_i | input | 1 | AC adapter present |
| sw_flag_i | input | 1 | Software-settable AC activity flag |
| mmio_strb_i | input | 1 | Memory-mapped cycle strobe |
| ac_en_i | input | 1 | Enable for AC activity counting |
| smi_busy_i | input | 1 | SMI service in progress |
| nmi_busy_i | input | 1 | NMI service in progress |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 activity mask, 1 resume mask |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| mode_set_i | input | 1 | Load a mode from the step-down controller |
| mode_set_val_i | input | 3 | Mode to load |
| act_pulse_o | output | 1 | One-cycle activity pulse |
| mode_o | output | 3 | Current power mode |

## Verification
The bench targets the two-sided effect of one mask. In the same Sleep state it sends IRQ5 activity, then IRQ3 with its resume enable clear, then IRQ3 with the enable set. A design that tied waking to the activity mask alone would wake too early, and one that needed both masks would miss the masked IRQ8 wake. It holds SMI or NMI high across the registering edge and then watches the quiet cycles that follow. A design that queued the gated event instead of dropping it would pulse late there. It also covers the AC enable gate, DRQ5-7 sharing one mask bit, a held level that must not pulse twice, an illegal mode-set value, and a step-down that lands on the same edge as a raise, which a wrong priority would let through.

// File: rtl/pmu_wake_pkg.sv
package pmu_wake_pkg;

  localparam int MODE_W  = 3;
  localparam int ACT_W   = 8;
  localparam int RES_W   = 3;
  localparam int IRQ_HI  = 15;
  localparam int DRQ_GRP = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_OFF   = 3'd0,
    PM_SUSP  = 3'd1,
    PM_SLEEP = 3'd2,
    PM_DOZE  = 3'd3,
    PM_LOSPD = 3'd4,
    PM_HISPD = 3'd5
  } pm_mode_e;

  // activity mask bit positions (software-visible, fixed)
  localparam int B_INT   = 7;
  localparam int B_AC    = 6;
  localparam int B_MMS   = 5;
  localparam int B_KB    = 4;
  localparam int B_DRQ3  = 3;
  localparam int B_DRQ2  = 2;
  localparam int B_DRQ1  = 1;
  localparam int B_DRQHI = 0;

  function automatic logic is_slow_run(logic [MODE_W-1:0] m);
    return (m == PM_DOZE) || (m == PM_LOSPD);
  endfunction

  function automatic logic is_asleep(logic [MODE_W-1:0] m);
    return (m == PM_OFF) || (m == PM_SUSP) || (m == PM_SLEEP);
  endfunction

  function automatic logic mode_legal(logic [MODE_W-1:0] m);
    return m <= PM_HISPD;
  endfunction

  // masked events; AC needs the extra enable
  function automatic logic [ACT_W-1:0] qualify(logic [ACT_W-1:0] ev,
                                               logic [ACT_W-1:0] mask,
                                               logic             ac_en);
    logic [ACT_W-1:0] q;
    q       = ev & ~mask;
    q[B_AC] = q[B_AC] & ac_en;
    return q;
  endfunction

  // raise and wake take precedence over an external load
  function automatic logic [MODE_W-1:0] next_mode(logic [MODE_W-1:0] cur,
                                                  logic              act,
                                                  logic              wake,
                                                  logic              set,
                                                  logic [MODE_W-1:0] setv);
    if (is_slow_run(cur) && act)  return PM_HISPD;
    if (is_asleep(cur) && wake)   return PM_HISPD;
    if (set && mode_legal(setv))  return setv;
    return cur;
  endfunction

endpackage

// File: rtl/pmu_sync_edge.sv
module pmu_sync_edge #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [W-1:0]             last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      last_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
      last_q <= pipe_q[STAGES-1];
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~last_q;

  // R3
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/pmu_act_qual.sv
module pmu_act_qual
  import pmu_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_HI:1]   irq_rise_i,
  input  logic [DRQ_GRP:1]  drq_lo_rise_i,
  input  logic [DRQ_GRP-1:0] drq_hi_rise_i,
  input  logic              ac_rise_i,
  input  logic              sw_rise_i,
  input  logic              mms_rise_i,
  input  logic [ACT_W-1:0]  act_mask_i,
  input  logic [RES_W-1:0]  res_mask_i,
  input  logic              ac_en_i,
  input  logic              gate_i,
  output logic [ACT_W-1:0]  ev_o,
  output logic              act_hit_o,
  output logic              wake_hit_o
);
  logic [RES_W-1:0] wake_src;
  logic [ACT_W-1:0] counted;

  always_comb begin
    ev_o          = '0;
    ev_o[B_INT]   = |irq_rise_i[IRQ_HI:2];
    ev_o[B_AC]    = ac_rise_i | sw_rise_i;
    ev_o[B_MMS]   = mms_rise_i;
    ev_o[B_KB]    = irq_rise_i[1];
    ev_o[B_DRQ3]  = drq_lo_rise_i[3];
    ev_o[B_DRQ2]  = drq_lo_rise_i[2];
    ev_o[B_DRQ1]  = drq_lo_rise_i[1];
    ev_o[B_DRQHI] = |drq_hi_rise_i;
  end

  assign wake_src   = {irq_rise_i[8], irq_rise_i[4], irq_rise_i[3]};
  assign counted    = qualify(ev_o, act_mask_i, ac_en_i);
  assign act_hit_o  = (|counted) & ~gate_i;
  assign wake_hit_o = (|(wake_src & res_mask_i)) & ~gate_i;

  // R5
  ac_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ac_en_i && ((ev_o & ~(ACT_W'(1) << B_AC)) == '0)) |-> !act_hit_o);

endmodule

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
  import pmu_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic              wake_i,
  input  logic              set_i,
  input  logic [MODE_W-1:0] setv_i,
  output logic [MODE_W-1:0] mode_o
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_HISPD;
    else        mode_q <= next_mode(mode_q, act_i, wake_i, set_i, setv_i);
  end

  assign mode_o = mode_q;

  // R7
  slow_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slow_run(mode_q) && act_i) |=> (mode_q == PM_HISPD));

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_asleep($past(mode_q)) && (mode_q == PM_HISPD) && !$past(set_i)) |-> $past(wake_i));

  // R10
  legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_legal(mode_q));

endmodule

// File: rtl/pmu_wake_ctrl.sv
module pmu_wake_ctrl
  import pmu_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_HI:1]   irq_i,
  input  logic [3:1]        drq_lo_i,
  input  logic [7:5]        drq_hi_i,
  input  logic              ac_in_i,
  input  logic              sw_flag_i,
  input  logic              mmio_strb_i,
  input  logic              ac_en_i,
  input  logic              smi_busy_i,
  input  logic              nmi_busy_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              mode_set_i,
  input  logic [MODE_W-1:0] mode_set_val_i,
  output logic              act_pulse_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int IRQ_N  = IRQ_HI;
  localparam int RAW_W  = IRQ_N + 2*DRQ_GRP + 3;
  localparam int P_DLO  = IRQ_N;
  localparam int P_DHI  = P_DLO + DRQ_GRP;
  localparam int P_AC   = P_DHI + DRQ_GRP;
  localparam int P_SW   = P_AC + 1;
  localparam int P_MMS  = P_SW + 1;

  logic [ACT_W-1:0] act_mask_q;
  logic [RES_W-1:0] res_mask_q;
  logic             act_pulse_q;

  logic [RAW_W-1:0]  raw;
  logic [RAW_W-1:0]  rise;
  logic [IRQ_HI:1]   irq_rise;
  logic [DRQ_GRP:1]  drq_lo_rise;
  logic [DRQ_GRP-1:0] drq_hi_rise;
  logic [ACT_W-1:0]  ev_vec;
  logic              act_hit;
  logic              wake_hit;
  logic              gate;

  // register port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mask_q <= '0;
      res_mask_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i) res_mask_q <= reg_wdata_i[RES_W-1:0];
      else            act_mask_q <= reg_wdata_i;
    end
  end

  assign reg_rdata_o = reg_addr_i ? {{(8-RES_W){1'b0}}, res_mask_q} : act_mask_q;

  // synchronise and edge-detect every source
  assign raw = {mmio_strb_i, sw_flag_i, ac_in_i, drq_hi_i, drq_lo_i, irq_i};

  pmu_sync_edge #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (raw),
    .rise_o (rise)
  );

  assign irq_rise    = rise[IRQ_N-1:0];
  assign drq_lo_rise = rise[P_DHI-1:P_DLO];
  assign drq_hi_rise = rise[P_AC-1:P_DHI];
  assign gate        = smi_busy_i | nmi_busy_i;

  pmu_act_qual u_qual (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_rise_i    (irq_rise),
    .drq_lo_rise_i (drq_lo_rise),
    .drq_hi_rise_i (drq_hi_rise),
    .ac_rise_i     (rise[P_AC]),
    .sw_rise_i     (rise[P_SW]),
    .mms_rise_i    (rise[P_MMS]),
    .act_mask_i    (act_mask_q),
    .res_mask_i    (res_mask_q),
    .ac_en_i       (ac_en_i),
    .gate_i        (gate),
    .ev_o          (ev_vec),
    .act_hit_o     (act_hit),
    .wake_hit_o    (wake_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_pulse_q <= 1'b0;
    else        act_pulse_q <= act_hit;
  end

  assign act_pulse_o = act_pulse_q;

  pmu_mode_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_i  (act_hit),
    .wake_i (wake_hit),
    .set_i  (mode_set_i),
    .setv_i (mode_set_val_i),
    .mode_o (mode_o)
  );

  // R6
  gate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> !act_pulse_o);

  // R4
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mask_q == '1) |=> !act_pulse_o);

  // R4
  pulse_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse_o |-> ($past(ev_vec) != '0));

endmodule

// File: tb/tb_pmu_wake_ctrl.sv
module tb_pmu_wake_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] irq = '0;
  logic [3:1]  dlo = '0;
  logic [7:5]  dhi = '0;
  logic        ac_in = 1'b0, sw_flag = 1'b0, mms = 1'b0, ac_en = 1'b0;
  logic        smi = 1'b0, nmi = 1'b0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mode_set = 1'b0;
  logic [2:0]  mode_val = '0;
  logic        act_pulse;
  logic [2:0]  mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_wake_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .drq_lo_i(dlo), .drq_hi_i(dhi),
    .ac_in_i(ac_in), .sw_flag_i(sw_flag), .mmio_strb_i(mms), .ac_en_i(ac_en),
    .smi_busy_i(smi), .nmi_busy_i(nmi), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mode_set_i(mode_set),
    .mode_set_val_i(mode_val), .act_pulse_o(act_pulse), .mode_o(mode)
  );

  typedef struct { logic act; logic [2:0] mode; string tag; } exp_t;
  exp_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  logic [2:0] mdl_mode = 3'd5;

  task automatic check(logic [7:0] got, logic [7:0] exp, string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic push(logic a, logic [2:0] m, string tag);
    exp_t e;
    e.act = a; e.mode = m; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: one expected item per clock, sampled after the edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check({7'b0, act_pulse}, {7'b0, e.act}, {e.tag, " pulse"});
        check({5'b0, mode}, {5'b0, e.mode}, {e.tag, " mode"});
      end
    end
  end

  function automatic logic [15:1] irq_bit(int n);
    logic [15:1] v;
    v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  // driver: raise sources, hold 4 cycles, drop them, 4 quiet cycles
  task automatic stim(logic [15:1] i_v, logic [3:1] lo_v, logic [7:5] hi_v,
                      logic [2:0] misc, logic [1:0] gt, logic doset,
                      logic [2:0] setv, logic exp_act, logic [2:0] exp_mode,
                      string tag);
    @(negedge clk);
    irq = i_v; dlo = lo_v; dhi = hi_v;
    ac_in = misc[0]; sw_flag = misc[1]; mms = misc[2];
    smi = gt[0]; nmi = gt[1];
    push(1'b0, mdl_mode, tag);
    push(1'b0, mdl_mode, tag);
    push(exp_act, exp_mode, tag);
    push(1'b0, exp_mode, tag);
    @(negedge clk);
    @(negedge clk);
    if (doset) begin mode_set = 1'b1; mode_val = setv; end
    @(negedge clk);
    mode_set = 1'b0;
    @(negedge clk);
    irq = '0; dlo = '0; dhi = '0; ac_in = 0; sw_flag = 0; mms = 0; smi = 0; nmi = 0;
    mdl_mode = exp_mode;
    for (int k = 0; k < 4; k++) push(1'b0, mdl_mode, {tag, " fall"});
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(logic [2:0] v, string tag);
    @(negedge clk);
    mode_set = 1'b1; mode_val = v;
    if (v <= 3'd5) mdl_mode = v;
    push(1'b0, mdl_mode, tag);
    @(negedge clk);
    mode_set = 1'b0;
  endtask

  task automatic reg_write(logic a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read_chk(logic a, logic [7:0] e, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata, e, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({7'b0, act_pulse}, 8'h00, "R1 pulse");
    check({5'b0, mode}, 8'h05, "R1 mode");
    reg_read_chk(1'b0, 8'h00, "R1 act mask");
    reg_read_chk(1'b1, 8'h00, "R1 resume mask");

    // R2 register port
    reg_write(1'b0, 8'hA5);
    reg_read_chk(1'b0, 8'hA5, "R2 act mask");
    reg_write(1'b1, 8'hFF);
    reg_read_chk(1'b1, 8'h07, "R2 resume mask");
    reg_read_chk(1'b0, 8'hA5, "R2 act mask kept");
    reg_write(1'b0, 8'h00);
    reg_write(1'b1, 8'h00);

    // R3 every source in High-Speed mode, single pulse
    stim(irq_bit(5), '0, '0, '0, '0, 0, '0, 1, 3'd5, "R3 irq5");
    stim(irq_bit(1), '0, '0, '0, '0, 0, '0, 1, 3'd5, "R3 irq1");
    stim(irq_bit(15), '0, '0, '0, '0, 0, '0, 1, 3'd5, "R3 irq15");
    stim('0, 3'b100, '0, '0, '0, 0, '0, 1, 3'd5, "R3 drq3");
    stim('0, 3'b010, '0, '0, '0, 0, '0, 1, 3'd5, "R3 drq2");
    stim('0, 3'b001, '0, '0, '0, 0, '0, 1, 3'd5, "R3 drq1");
    stim('0, '0, 3'b010, '0, '0, 0, '0, 1, 3'd5, "R3 drq6");
    stim('0, '0, '0, 3'b100, '0, 0, '0, 1, 3'd5, "R3 mmio");

    // R5 AC gating by enable and mask bit 6
    stim('0, '0, '0, 3'b001, '0, 0, '0, 0, 3'd5, "R5 ac no enable");
    ac_en = 1'b1;
    stim('0, '0, '0, 3'b001, '0, 0, '0, 1, 3'd5, "R5 ac enabled");
    stim('0, '0, '0, 3'b010, '0, 0, '0, 1, 3'd5, "R5 sw flag");
    reg_write(1'b0, 8'h40);
    stim('0, '0, '0, 3'b001, '0, 0, '0, 0, 3'd5, "R5 ac masked");

    // R4 masking
    reg_write(1'b0, 8'h80);
    stim(irq_bit(5), '0, '0, '0, '0, 0, '0, 0, 3'd5, "R4 int masked");
    stim(irq_bit(1), '0, '0, '0, '0, 0, '0, 1, 3'd5, "R4 kb still counts");
    reg_write(1'b0, 8'h01);
    stim('0, '0, 3'b100, '0, '0, 0, '0, 0, 3'd5, "R4 drq7 masked");
    reg_write(1'b0, 8'hFF);
    stim('0, 3'b100, '0, '0, '0, 0, '0, 0, 3'd5, "R4 all masked");
    reg_write(1'b0, 8'h00);

    // R6 SMI/NMI gating drops the event
    set_mode(3'd4, "R10 load lospd");
    stim(irq_bit(5), '0, '0, '0, 2'b01, 0, '0, 0, 3'd4, "R6 smi drop");
    stim('0, 3'b001, '0, '0, 2'b10, 0, '0, 0, 3'd4, "R6 nmi drop");

    // R7 raise from Low-Speed and Doze
    stim(irq_bit(5), '0, '0, '0, '0, 0, '0, 1, 3'd5, "R7 lospd raise");
    set_mode(3'd3, "R10 load doze");
    stim('0, 3'b010, '0, '0, '0, 0, '0, 1, 3'd5, "R7 doze raise");

    // R10 illegal value and precedence
    set_mode(3'd6, "R10 illegal ignored");
    set_mode(3'd4, "R10 load lospd");
    stim(irq_bit(5), '0, '0, '0, '0, 1, 3'd0, 1, 3'd5, "R10 raise beats set");

    // R8 / R9 sleep-class behaviour
    set_mode(3'd2, "R10 load sleep");
    stim(irq_bit(5), '0, '0, '0, '0, 0, '0, 1, 3'd2, "R8 no wake irq5");
    stim(irq_bit(3), '0, '0, '0, '0, 0, '0, 1, 3'd2, "R9 irq3 not enabled");
    reg_write(1'b1, 8'h01);
    stim(irq_bit(3), '0, '0, '0, '0, 0, '0, 1, 3'd5, "R9 irq3 wake");
    set_mode(3'd0, "R10 load off");
    reg_write(1'b0, 8'h80);
    reg_write(1'b1, 8'h04);
    stim(irq_bit(8), '0, '0, '0, '0, 0, '0, 0, 3'd5, "R9 irq8 wake masked");
    set_mode(3'd1, "R10 load suspend");
    reg_write(1'b0, 8'h00);
    reg_write(1'b1, 8'h02);
    stim(irq_bit(4), '0, '0, '0, 2'b01, 0, '0, 0, 3'd1, "R6 wake gated");
    stim(irq_bit(4), '0, '0, '0, '0, 0, '0, 1, 3'd5, "R9 irq4 wake");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) check(8'(sb_q.size()), 8'h00, "R3 scoreboard drained");
    finish_run();
  end

endmodule